// File: doc/BRIEF.md
# Dual Gate-Driver Supervisor

This block is the digital control core that sits between a controller and two isolated gate-driver channels. Each channel takes a gate command from the controller and passes it to its gate output, but only when several conditions hold. The enable input must be high. The input-side supply must be out of undervoltage lockout and must have been valid for a full start-up interval. The channel's own driver supply must be out of lockout. When any of these conditions fails, the gate output is driven low. A ready output reports whether all three supplies are currently good.

The undervoltage flags arrive as clean digital levels, where 1 means in lockout. Each flag and the enable pass through a two-flop synchronizer. The channel commands are taken as already synchronous to `clk`, so they reach the gates through a single output register. The start-up interval is counted in clock cycles, `CLK_MHZ * START_US`. It restarts whenever the input supply re-enters lockout.

The parameter `CROSS_TRIP` selects the enhanced mode. In that mode, a lockout on either driver supply also forces the opposite channel low, which keeps a transformer-coupled pair balanced. The enable pin is meant to have an external pull-down, so an undriven pin reads as low.

Top module: `gate_supervisor`

## Requirements
- R1: While the synchronized enable is low, both gate outputs are low whatever the commands are. A falling enable drives the gates low on the SYNC_STAGES+1-th rising edge after the change.
- R2: While the input-supply lockout flag `uv_in` is 1, both gates stay low, and toggling enable has no effect on them.
- R3: After `uv_in` falls, both gates stay low through SYNC_STAGES+START_CYC rising edges. With enable high, both supplies good and a command of 1, the gate is high after the next edge. Raising `uv_in` again restarts the interval from zero.
- R4: A channel's gate is low while its own driver-supply flag (`uv_a` for gate A, `uv_b` for gate B) is 1. When `CROSS_TRIP` is 0, the other channel keeps following its command.
- R5: When `CROSS_TRIP` is 1, `uv_a`=1 also forces `gate_b` low, and `uv_b`=1 also forces `gate_a` low.
- R6: `ready` is 1 exactly when all three lockout flags were 0 SYNC_STAGES+1 edges earlier. It returns to 1 without any reset once the supplies recover.
- R7: With all supplies good, the start-up interval elapsed and enable high, each gate equals its command one edge later: 1 gives high, 0 gives low.
- R8: A rising enable lets the gates follow their commands again on the SYNC_STAGES+1-th edge after the change, with no new start-up interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_a | input | 1 | Gate command for channel A, synchronous to clk |
| cmd_b | input | 1 | Gate command for channel B, synchronous to clk |
| enable | input | 1 | Active-high run enable, asynchronous |
| uv_in | input | 1 | Input-side supply lockout flag, 1 = in lockout |
| uv_a | input | 1 | Driver A supply lockout flag, 1 = in lockout |
| uv_b | input | 1 | Driver B supply lockout flag, 1 = in lockout |
| gate_a | output | 1 | Registered gate output for channel A |
| gate_b | output | 1 | Registered gate output for channel B |
| ready | output | 1 | 1 when all three supplies are out of lockout |

## Verification
The bench builds the block with `CLK_MHZ`=4 and `START_US`=5, so the start-up interval is 20 cycles. At that length the exact edge where the gates are released can be checked both at first power-up and after a re-entry into lockout. Two instances run side by side on identical stimulus: one with `CROSS_TRIP`=0 and one with `CROSS_TRIP`=1. Every driver-supply fault pattern therefore shows both the independent lockout and the cross-channel lockout in the same cycle.

// File: rtl/gs_pkg.sv
package gs_pkg;
  // Synchronized control bundle, one bit per asynchronous input.
  typedef struct packed {
    logic in_lock;
    logic a_lock;
    logic b_lock;
    logic en;
  } gs_ctl_t;

  localparam int unsigned CTL_W = $bits(gs_ctl_t);
  // Safe reset view: all supplies in lockout, enable off.
  localparam gs_ctl_t CTL_RST = '{in_lock: 1'b1, a_lock: 1'b1, b_lock: 1'b1, en: 1'b0};
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gs_start_timer.sv
module gs_start_timer #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_lock,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (in_lock)      cnt <= '0;
    else if (cnt != TOP)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);

  // R3: any lockout restarts the interval, so done is gone one edge later
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |=> !done);
endmodule

// File: rtl/gs_channel_gate.sv
module gs_channel_gate #(
  parameter bit CROSS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic own_lock,
  input  logic peer_lock,
  input  logic cmd,
  output logic gate
);
  logic allow;

  generate
    if (CROSS) begin : g_cross
      assign allow = run & ~own_lock & ~peer_lock;
      // R5: a fault on the other driver supply trips this channel
      assert_peer_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        peer_lock |=> !gate);
    end else begin : g_indep
      assign allow = run & ~own_lock;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= cmd & allow;
  end

  // R4: own supply in lockout gives a low gate
  assert_own_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    own_lock |=> !gate);
  // R1: no run permission gives a low gate
  assert_norun_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !gate);
endmodule

// File: rtl/gate_supervisor.sv
module gate_supervisor
  import gs_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned START_US = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit CROSS_TRIP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic enable,
  input  logic uv_in,
  input  logic uv_a,
  input  logic uv_b,
  output logic gate_a,
  output logic gate_b,
  output logic ready
);
  localparam int unsigned START_CYC = CLK_MHZ * START_US;

  gs_ctl_t ctl_raw, ctl_s;
  logic    start_done;
  logic    run;

  assign ctl_raw = '{in_lock: uv_in, a_lock: uv_a, b_lock: uv_b, en: enable};

  gs_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  gs_start_timer #(.LIMIT(START_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .in_lock(ctl_s.in_lock), .done(start_done)
  );

  assign run = ctl_s.en & start_done & ~ctl_s.in_lock;

  gs_channel_gate #(.CROSS(CROSS_TRIP)) u_ch_a (
    .clk(clk), .rst_n(rst_n), .run(run),
    .own_lock(ctl_s.a_lock), .peer_lock(ctl_s.b_lock),
    .cmd(cmd_a), .gate(gate_a)
  );

  gs_channel_gate #(.CROSS(CROSS_TRIP)) u_ch_b (
    .clk(clk), .rst_n(rst_n), .run(run),
    .own_lock(ctl_s.b_lock), .peer_lock(ctl_s.a_lock),
    .cmd(cmd_b), .gate(gate_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= ~(ctl_s.in_lock | ctl_s.a_lock | ctl_s.b_lock);
  end

  // R2: input-side lockout holds both gates low
  assert_inlock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.in_lock |=> (!gate_a && !gate_b));
  // R1: synchronized enable low holds both gates low
  assert_disable_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_s.en |=> (!gate_a && !gate_b));
  // R6: any supply lockout drops ready
  assert_ready_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_s.in_lock || ctl_s.a_lock || ctl_s.b_lock) |=> !ready);
  // R6: all supplies good raises ready without reset
  assert_ready_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_s.in_lock || ctl_s.a_lock || ctl_s.b_lock) |=> ready);
endmodule

// File: tb/gate_supervisor_test.sv
module gate_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int LIMIT = 4 * 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_a = 1'b0, cmd_b = 1'b0, enable = 1'b0;
  logic uv_in = 1'b1, uv_a = 1'b1, uv_b = 1'b1;
  logic ga, gb, rdy, gae, gbe, rdye;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_supervisor #(.CLK_MHZ(4), .START_US(5), .SYNC_STAGES(SYNC), .CROSS_TRIP(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .enable(enable),
    .uv_in(uv_in), .uv_a(uv_a), .uv_b(uv_b), .gate_a(ga), .gate_b(gb), .ready(rdy));

  gate_supervisor #(.CLK_MHZ(4), .START_US(5), .SYNC_STAGES(SYNC), .CROSS_TRIP(1'b1)) uut_x (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b), .enable(enable),
    .uv_in(uv_in), .uv_a(uv_a), .uv_b(uv_b), .gate_a(gae), .gate_b(gbe), .ready(rdye));

  // {en, uv_a, uv_b, cmd_a, cmd_b, exp ga, gb, ga_cross, gb_cross, ready}
  localparam logic [9:0] VEC [10] = '{
    10'b10010_10101,  // R7 A high, B low
    10'b10001_01011,  // R7 A low, B high
    10'b10011_11111,  // R7 both high
    10'b00011_00001,  // R1 disabled
    10'b11011_01000,  // R4 R5 driver A lockout
    10'b10111_10000,  // R4 R5 driver B lockout
    10'b11111_00000,  // R4 both lockout
    10'b10011_11111,  // R6 recovery without reset
    10'b01011_00000,  // R1 disabled with fault
    10'b10000_00001   // R7 commands low
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary_end();
  end

  initial begin
    step(3);
    chk("reset gate_a", ga, 1'b0);
    chk("reset gate_b", gb, 1'b0);
    chk("reset ready", rdy, 1'b0);
    rst_n = 1'b1;

    // R2: input lockout with driver supplies good, enable toggling
    uv_a = 1'b0; uv_b = 1'b0; enable = 1'b1; cmd_a = 1'b1; cmd_b = 1'b1;
    step(10);
    chk("R2 gate_a in input lockout", ga, 1'b0);
    chk("R2 gate_b in input lockout", gb, 1'b0);
    chk("R6 ready in input lockout", rdy, 1'b0);
    enable = 1'b0; step(4); enable = 1'b1; step(4);
    chk("R2 enable toggle no effect", ga | gb | gae | gbe, 1'b0);

    // R3: exact release edge after input becomes valid
    uv_in = 1'b0;
    step(SYNC + LIMIT);
    chk("R3 held low at end of interval", ga | gb, 1'b0);
    chk("R6 ready before interval ends", rdy, 1'b1);
    step(1);
    chk("R3 gate_a released", ga, 1'b1);
    chk("R3 gate_b released", gb, 1'b1);
    chk("R3 cross instance released", gae & gbe, 1'b1);

    // R1 / R8: enable latency
    enable = 1'b0;
    step(SYNC);
    chk("R1 gate still high before latency", ga, 1'b1);
    step(1);
    chk("R1 gate_a low after disable", ga, 1'b0);
    chk("R1 gate_b low after disable", gb, 1'b0);
    enable = 1'b1;
    step(SYNC);
    chk("R8 gate still low before latency", ga, 1'b0);
    step(1);
    chk("R8 gate_a resumes", ga, 1'b1);
    chk("R8 gate_b resumes", gb, 1'b1);

    // R7: one-edge command latency
    cmd_a = 1'b0;
    step(1);
    chk("R7 gate_a follows low command", ga, 1'b0);
    cmd_a = 1'b1;
    step(1);
    chk("R7 gate_a follows high command", ga, 1'b1);

    // Vector table
    for (int i = 0; i < 10; i++) begin
      enable = VEC[i][9]; uv_a = VEC[i][8]; uv_b = VEC[i][7];
      cmd_a = VEC[i][6]; cmd_b = VEC[i][5];
      step(SYNC + 2);
      chk("R4/R7 vec gate_a", ga, VEC[i][4]);
      chk("R4/R7 vec gate_b", gb, VEC[i][3]);
      chk("R5 vec cross gate_a", gae, VEC[i][2]);
      chk("R5 vec cross gate_b", gbe, VEC[i][1]);
      chk("R6 vec ready", rdy, VEC[i][0]);
      chk("R6 vec cross ready", rdye, VEC[i][0]);
    end

    // R3: restart after re-entering input lockout
    enable = 1'b1; uv_a = 1'b0; uv_b = 1'b0; cmd_a = 1'b1; cmd_b = 1'b1;
    step(SYNC + 2);
    chk("R3 running before re-lockout", ga & gb, 1'b1);
    uv_in = 1'b1;
    step(SYNC + 1);
    chk("R2 gates low after input lockout", ga | gb, 1'b0);
    chk("R6 ready low after input lockout", rdy, 1'b0);
    uv_in = 1'b0;
    step(SYNC + LIMIT);
    chk("R3 restart held low", ga | gb | gae | gbe, 1'b0);
    step(1);
    chk("R3 restart released", ga & gb & gae & gbe, 1'b1);

    summary_end();
  end
endmodule